// File: doc/BRIEF.md
# Dual-Base Programmable Clock Prescaler

This block supplies timer counters with a set of periodic clock-enable pulses taken from the system clock. A shared divider chain starts from a base stage that divides by 2 or by 3. Five fixed taps follow from that stage at successive powers of two. A sixth tap's ratio is chosen by software from four settings. Every tap is a pulse one system clock wide, issued once per period, so consumers keep running on the system clock and only use the pulse as an enable.

A run control gates the whole chain. While it is low the chain is held at zero. Setting it high again restarts all counts from zero, and any change to the base or tap-select settings restarts them the same way. An external pin offers a seventh source. It is synchronized through a two-stage flop chain, and each rising or falling edge, as programmed, gives a single-cycle pulse. Each consumer has a 3-bit source code that routes one of these seven pulses, or none, to its own enable output.

Top module: `dual_base_prescaler`

## Requirements
- R1: With `baseTri`=0 and the chain running, tapPulse[0..4] fire with periods of 2, 4, 8, 16 and 32 cycles. Each pulse is one cycle wide, and a tap of ratio N fires in the cycles where (n+1) mod N = 0, where n is the number of cycles since the chain restarted.
- R2: With `baseTri`=1, tapPulse[0..4] fire with periods of 3, 6, 12, 24 and 48 cycles, using the same phase rule.
- R3: With `baseTri`=0, tapPulse[5] has a period of 64, 128, 256 or 512 cycles for `tapSel` values 0, 1, 2 and 3.
- R4: With `baseTri`=1, tapPulse[5] has a period of 96, 192, 384 or 768 cycles for `tapSel` values 0, 1, 2 and 3.
- R5: In the cycle after a clock edge that samples `runEn`=0, every tapPulse bit is 0, whatever `baseTri` and `tapSel` hold.
- R6: After a clock edge that samples `runEn`=1 following a cycle with `runEn`=0, counting restarts from n=0. A tap of ratio N therefore first fires after the N-th edge that samples `runEn` high.
- R7: A clock edge that samples a `baseTri` or `tapSel` value different from the previous sample restarts counting from n=0 under the new settings, with the same timing as R6.
- R8: `extPulse` is high for one cycle when the pin level seen through a two-flop synchronizer changes. With `extFall`=0 it fires on a 0-to-1 change, and with `extFall`=1 on a 1-to-0 change. A pin change set up before edge k shows up in the cycle after edge k+1. `extPulse` does not depend on `runEn`.
- R9: For consumer c, source code `srcSel[3c+2:3c]` routes a source to `consEn[c]`: codes 0 to 5 select tapPulse[0] to tapPulse[5], code 6 selects `extPulse`, and code 7 drives 0.
- R10: While `rstN` is low, tapPulse, extPulse and consEn are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Run control for the divider chain |
| baseTri | input | 1 | Base stage select: 0 divides by 2, 1 divides by 3 |
| tapSel | input | 2 | Ratio code for the sixth tap |
| extPin | input | 1 | Asynchronous external event pin |
| extFall | input | 1 | External edge polarity: 0 rising, 1 falling |
| srcSel | input | 12 | Four 3-bit source codes, consumer c in bits 3c+2:3c |
| tapPulse | output | 6 | Tap enable pulses, index 0 fastest, index 5 software-selected |
| extPulse | output | 1 | Qualified external edge pulse |
| consEn | output | 4 | Per-consumer selected enable |

## Verification
The embedded properties watch several invariants on every cycle. Taps are silent after run was sampled low. A slower fixed tap never fires without the faster one beside it. The base counter stays within its modulus, and the chain is zero after any clear or run restart. The edge pulse never repeats in back-to-back cycles under a steady polarity. Only the bench's behavioural model can confirm the exact periods and phase of each tap in both bases and for all four sixth-tap codes, that the first period after a restart or a settings change is full length, the synchronizer latency of the external pulse, and the routing of every source code to each consumer.

// File: rtl/presc_pkg.sv
package presc_pkg;
  localparam int unsigned SEL_W = 2;

  typedef struct packed {
    logic             running;
    logic             clearChain;
    logic             advance;
    logic             baseTri;
    logic [SEL_W-1:0] tapSel;
  } presc_strobe_t;
endpackage

// File: rtl/presc_ctrl.sv
module presc_ctrl
  import presc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               runEn,
  input  logic               baseTri,
  input  logic [SEL_W-1:0]   tapSel,
  output presc_strobe_t      strobe
);
  logic             runQ;
  logic             baseQ;
  logic [SEL_W-1:0] selQ;
  logic             cfgDiff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      baseQ <= 1'b0;
      selQ  <= '0;
    end else begin
      runQ  <= runEn;
      baseQ <= baseTri;
      selQ  <= tapSel;
    end
  end

  always_comb begin
    cfgDiff           = (baseTri != baseQ) || (tapSel != selQ);
    strobe.clearChain = !runEn || cfgDiff;
    strobe.advance    = runQ && !strobe.clearChain;
    strobe.running    = runQ;
    strobe.baseTri    = baseQ;
    strobe.tapSel     = selQ;
  end

  // R6
  run_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.running |-> $past(runEn));
endmodule

// File: rtl/presc_datapath.sv
module presc_datapath
  import presc_pkg::*;
#(
  parameter int unsigned FIXED_TAPS = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  presc_strobe_t       strobe,
  output logic [FIXED_TAPS:0] tapPulse
);
  localparam int unsigned SEL_CODES = 1 << SEL_W;
  localparam int unsigned CHAIN_W   = FIXED_TAPS + SEL_CODES - 1;

  logic [1:0]         baseCnt;
  logic [CHAIN_W-1:0] chainCnt;
  logic               baseLast;
  logic               periodEnd;

  function automatic logic lowOnes(input logic [CHAIN_W-1:0] v, input int unsigned n);
    logic [CHAIN_W-1:0] mask;
    if (n >= CHAIN_W) mask = '1;
    else              mask = (CHAIN_W'(1) << n) - CHAIN_W'(1);
    return (v & mask) == mask;
  endfunction

  assign baseLast  = strobe.baseTri ? (baseCnt == 2'd2) : (baseCnt == 2'd1);
  assign periodEnd = strobe.running && baseLast;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearChain) begin
      baseCnt  <= '0;
      chainCnt <= '0;
    end else if (strobe.advance) begin
      if (baseLast) begin
        baseCnt  <= '0;
        chainCnt <= chainCnt + CHAIN_W'(1);
      end else begin
        baseCnt  <= baseCnt + 2'd1;
      end
    end
  end

  for (genvar i = 0; i < FIXED_TAPS; i++) begin : g_fixed
    assign tapPulse[i] = periodEnd && lowOnes(chainCnt, i);
  end

  assign tapPulse[FIXED_TAPS] =
    periodEnd && lowOnes(chainCnt, FIXED_TAPS + int'(strobe.tapSel));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.clearChain) |-> (baseCnt == 2'd0 && chainCnt == '0));

  // R2
  base_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    baseCnt <= (strobe.baseTri ? 2'd2 : 2'd1));

  // R6
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.running) |-> (baseCnt == 2'd0 && chainCnt == '0));
endmodule

// File: rtl/presc_ext_sync.sv
module presc_ext_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic extPin,
  input  logic extFall,
  output logic extPulse
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   stableLvl;

  assign stableLvl = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], extPin};
      prevQ <= stableLvl;
    end
  end

  assign extPulse = extFall ? (prevQ && !stableLvl) : (stableLvl && !prevQ);

  // R8
  ext_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    extPulse |=> (!extPulse || (extFall != $past(extFall))));
endmodule

// File: rtl/dual_base_prescaler.sv
module dual_base_prescaler
  import presc_pkg::*;
#(
  parameter int unsigned FIXED_TAPS  = 5,
  parameter int unsigned NUM_CONS    = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SRC_W      = $clog2(FIXED_TAPS + 3)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      runEn,
  input  logic                      baseTri,
  input  logic [SEL_W-1:0]          tapSel,
  input  logic                      extPin,
  input  logic                      extFall,
  input  logic [NUM_CONS*SRC_W-1:0] srcSel,
  output logic [FIXED_TAPS:0]       tapPulse,
  output logic                      extPulse,
  output logic [NUM_CONS-1:0]       consEn
);
  localparam int unsigned EXT_CODE = FIXED_TAPS + 1;

  presc_strobe_t strobe;

  presc_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .runEn   (runEn),
    .baseTri (baseTri),
    .tapSel  (tapSel),
    .strobe  (strobe)
  );

  presc_datapath #(.FIXED_TAPS(FIXED_TAPS)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .tapPulse (tapPulse)
  );

  presc_ext_sync #(.SYNC_STAGES(SYNC_STAGES)) ext_i (
    .clk      (clk),
    .rstN     (rstN),
    .extPin   (extPin),
    .extFall  (extFall),
    .extPulse (extPulse)
  );

  for (genvar c = 0; c < NUM_CONS; c++) begin : g_cons
    logic [SRC_W-1:0] code;
    assign code = srcSel[c*SRC_W +: SRC_W];
    always_comb begin
      if (int'(code) <= FIXED_TAPS)     consEn[c] = tapPulse[code];
      else if (int'(code) == EXT_CODE)  consEn[c] = extPulse;
      else                              consEn[c] = 1'b0;
    end
  end

  // R5
  run_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(runEn) |-> (tapPulse == '0));

  for (genvar i = 0; i < FIXED_TAPS; i++) begin : g_nest
    // R1
    tap_nest_chk: assert property (@(posedge clk) disable iff (!rstN)
      tapPulse[i+1] |-> tapPulse[i]);
  end
endmodule

// File: tb/dual_base_prescaler_tb_top.sv
`timescale 1ns/1ps
module dual_base_prescaler_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic        baseTri = 1'b0;
  logic [1:0]  tapSel = 2'd0;
  logic        extPin = 1'b0;
  logic        extFall = 1'b0;
  logic [11:0] srcSel = '0;
  logic [5:0]  tapPulse;
  logic        extPulse;
  logic [3:0]  consEn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_base_prescaler dut_i (
    .clk(clk), .rstN(rstN), .runEn(runEn), .baseTri(baseTri), .tapSel(tapSel),
    .extPin(extPin), .extFall(extFall), .srcSel(srcSel),
    .tapPulse(tapPulse), .extPulse(extPulse), .consEn(consEn)
  );

  // behavioural reference state
  int n = 0;
  bit mRun = 0, mBase = 0;
  int mSel = 0;
  int cause = 6;
  bit pinHist[$];

  always @(posedge clk) begin
    if (!rstN) begin
      n = 0; mRun = 0; mBase = 0; mSel = 0; cause = 6;
      pinHist = '{1'b0, 1'b0, 1'b0};
    end else begin
      if (!runEn || baseTri != mBase || int'(tapSel) != mSel) begin
        cause = (baseTri != mBase || int'(tapSel) != mSel) ? 7 : 6;
        n = 0;
      end else if (mRun) n++;
      mRun = runEn; mBase = baseTri; mSel = int'(tapSel);
      pinHist.push_front(extPin);
      void'(pinHist.pop_back());
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic bit expTap(input int i);
    int ratio;
    ratio = (mBase ? 3 : 2) << ((i < 5) ? i : 5 + mSel);
    return mRun && (((n + 1) % ratio) == 0);
  endfunction

  function automatic bit expExt();
    // pinHist[1] is the synchronized level, pinHist[2] the previous one
    return extFall ? (pinHist[2] && !pinHist[1]) : (pinHist[1] && !pinHist[2]);
  endfunction

  task automatic compareAll();
    bit e;
    int ratio;
    string tag;
    for (int i = 0; i < 6; i++) begin
      e = expTap(i);
      ratio = (mBase ? 3 : 2) << ((i < 5) ? i : 5 + mSel);
      if (!mRun) tag = "R5";
      else if (n < ratio) tag = (cause == 7) ? "R7" : "R6";
      else if (i < 5) tag = mBase ? "R2" : "R1";
      else tag = mBase ? "R4" : "R3";
      check(tapPulse[i] == e, $sformatf("%s tap%0d", tag, i), int'(tapPulse[i]), int'(e));
    end
    check(extPulse == expExt(), "R8 extPulse", int'(extPulse), int'(expExt()));
    for (int c = 0; c < 4; c++) begin
      int code;
      code = int'(srcSel[c*3 +: 3]);
      if (code <= 5) e = expTap(code);
      else if (code == 6) e = expExt();
      else e = 1'b0;
      check(consEn[c] == e, $sformatf("R9 consumer%0d code%0d", c, code), int'(consEn[c]), int'(e));
    end
  endtask

  task automatic runPhase(input bit run, input bit base, input int sel, input int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      compareAll();
      runEn   = run;
      baseTri = base;
      tapSel  = 2'(sel);
      if ($urandom % 3 == 0) extPin = ~extPin;
      if ($urandom % 50 == 0) extFall = ~extFall;
      srcSel  = 12'($urandom);
    end
  endtask

  initial begin
    pinHist = '{1'b0, 1'b0, 1'b0};
    extPin = 1'b1;
    runEn = 1'b1;
    srcSel = 12'hFFF;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      // R10
      check(tapPulse == '0, "R10 tapPulse in reset", int'(tapPulse), 0);
      check(extPulse == 1'b0, "R10 extPulse in reset", int'(extPulse), 0);
      srcSel = 12'($urandom);
      check(consEn == '0, "R10 consEn in reset", int'(consEn), 0);
    end
    runEn = 1'b0;
    extPin = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    runPhase(1, 0, 0, 1100);
    runPhase(1, 0, 1, 1100);
    runPhase(1, 0, 2, 1100);
    runPhase(1, 0, 3, 1100);
    runPhase(0, 0, 3, 60);
    runPhase(0, 1, 2, 20);
    runPhase(1, 0, 3, 1100);
    runPhase(1, 1, 0, 400);
    runPhase(1, 1, 1, 500);
    runPhase(1, 1, 2, 900);
    runPhase(1, 1, 3, 1600);
    runPhase(0, 1, 1, 7);
    runPhase(1, 1, 1, 250);
    runPhase(1, 0, 1, 37);
    runPhase(1, 1, 1, 300);
    runPhase(1, 1, 3, 1600);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule